// File: doc/BRIEF.md
# Supervisory Watchdog with Power-Good Control

This block watches a host for signs of life on behalf of a power-supply supervisor. Software restarts the timer by writing a non-zero period to the running-timeout register. The host can also restart it by toggling a watchdog input pin from low to high. If neither happens within the programmed period, the block pulls an active-low alert output. If so configured, it also drops power-good for a programmable number of milliseconds before raising it again. The first period after the timer is armed uses its own timeout value. Every later period uses the running value. Writing zero to either timeout register switches the timer off.

A 1 ms tick is taken from the system clock by a prescaler, and all periods and delays count in these ticks. The watchdog pin has a second duty. When it is held low for long enough, the block enters a power-on reset state and emits a one-cycle request strobe. The next rising edge on the pin then leaves that state and emits a one-cycle sequence-start strobe. The rail sequencing behind these strobes and the serial bus that carries the register writes live outside this block.

Top module: `wdog_supervisor`

## Requirements
- R1: After a write that makes both timeout registers non-zero, the alert falls exactly FIRST x CLK_PER_MS clock cycles after the clock edge that accepts the write, where FIRST is the value at address 0.
- R2: A non-zero write to the running-timeout register (address 1) while the timer is armed restarts it. The alert then falls exactly RUN x CLK_PER_MS cycles after the edge that accepts the latest such write, and a later restart pushes the expiry out.
- R3: A low-to-high change on the watchdog pin restarts an armed timer into the running period. The restart takes effect on the third clock edge after the pin rises, because of two synchroniser stages and one edge-detect stage.
- R4: On expiry alert_n goes low and stays low until a write to address 4, which releases it on the accepting edge. After an expiry the timer stops until it is restarted.
- R5: While the value at address 0 or at address 1 is zero, the timer is disarmed: no expiry, no alert and no power-good drop occur. A zero write to address 1 does not restart the timer.
- R6: With bit 0 of address 2 set, an expiry drives pg low on the same edge as the alert. pg returns high after max(D,1) ticks, where D is the value at address 3. With that bit clear, pg stays high.
- R7: A restart that arrives while pg is low does not shorten the power-good delay.
- R8: When the synchronised pin stays low for LONG_LOW_CYC cycles, por_req pulses high for exactly one cycle, LONG_LOW_CYC+2 edges after the pin falls. A shorter low level causes no request.
- R9: In the power-on reset state the timer does not count. The next rising pin edge pulses seq_start for one cycle, three edges after the rise, and re-arms the timer in its first period from that edge.
- R10: After reset alert_n and pg are high, both strobes are low, and every register holds zero, so the timer starts disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address: 0 first timeout, 1 running timeout, 2 config, 3 pg delay, 4 clear alert |
| wr_data | input | TMO_W | Register write data |
| wdi | input | 1 | Asynchronous watchdog pin, idles high |
| alert_n | output | 1 | Active-low sticky alert |
| pg | output | 1 | Power-good output |
| por_req | output | 1 | One-cycle power-on reset request |
| seq_start | output | 1 | One-cycle power-on sequence start |

## Verification
The bench times every alert, power-good and strobe edge to the exact cycle. A prescaler that is not cleared on restart, or a synchroniser with the wrong depth, moves an edge by a cycle or more and is caught. It also pulses the pin while power-good is low; a design that lets that restart cut the delay short raises pg early. It aims at disarming paths as well: a zero write, a running-timeout write made while the first-timeout register is zero, and the hold in power-on reset. A design that counts in any of these states raises an alert the bench does not expect. A minimum delay of zero ticks and a pin low level just short of the reset threshold are also exercised. Getting the first case wrong leaves pg stuck low; getting the second wrong emits a spurious reset request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    ADR_FIRST = 3'd0,
    ADR_RUN   = 3'd1,
    ADR_CFG   = 3'd2,
    ADR_PGDLY = 3'd3,
    ADR_CLEAR = 3'd4
  } wdog_addr_e;

  // Counter width able to hold values 0..n-1
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // True when one more step brings the count to the limit
  function automatic logic last_step(logic [31:0] cnt, logic [31:0] lim);
    return (cnt + 32'd1) == lim;
  endfunction

  // Power-good delay in ticks, never shorter than one tick
  function automatic logic [31:0] eff_delay(logic [31:0] d);
    return (d == 32'd0) ? 32'd1 : d;
  endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = wdog_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  // R1: ticks are spaced by the divider, never back to back
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/wdog_pin_mon.sv
module wdog_pin_mon #(
  parameter int unsigned LONG_LOW_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic por_active,
  output logic por_req,
  output logic seq_start
);
  localparam int unsigned LW = wdog_pkg::cnt_width(LONG_LOW_CYC);
  localparam logic [LW-1:0] LOW_LAST = LW'(LONG_LOW_CYC - 1);

  logic s1, s2, s3;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 && !s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= '0;
      por_active <= 1'b0;
      por_req    <= 1'b0;
      seq_start  <= 1'b0;
    end else begin
      por_req   <= 1'b0;
      seq_start <= 1'b0;
      if (por_active) begin
        low_cnt <= '0;
        if (rise) begin
          por_active <= 1'b0;
          seq_start  <= 1'b1;
        end
      end else if (s2) begin
        low_cnt <= '0;
      end else if (low_cnt == LOW_LAST) begin
        por_active <= 1'b1;
        por_req    <= 1'b1;
        low_cnt    <= '0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // R8: the reset request is a single-cycle strobe
  a_r8_por_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> !por_req);
  // R8: the reset state is only entered from a low synchronised pin
  a_r8_por_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_active) |-> !$past(s2));
  // R9: sequence start only leaves the reset state
  a_r9_seq_after_por: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> ($past(por_active) && !por_active));

endmodule

// File: rtl/wdog_timer_core.sv
module wdog_timer_core #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          hold,
  input  logic          restart,
  input  logic [TW-1:0] first_lim,
  input  logic [TW-1:0] run_lim,
  output logic          presc_clr,
  output logic          expire
);
  logic          in_run;
  logic          halted;
  logic [TW-1:0] elapsed;
  logic [TW-1:0] limit;
  logic          counting;

  assign counting  = enable && !hold && !halted;
  assign limit     = in_run ? run_lim : first_lim;
  assign expire    = counting && !restart && tick &&
                     wdog_pkg::last_step(32'(elapsed), 32'(limit));
  assign presc_clr = !counting || restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run  <= 1'b0;
      halted  <= 1'b0;
      elapsed <= '0;
    end else if (!enable || hold) begin
      in_run  <= 1'b0;
      halted  <= 1'b0;
      elapsed <= '0;
    end else if (restart) begin
      in_run  <= 1'b1;
      halted  <= 1'b0;
      elapsed <= '0;
    end else if (!halted && tick) begin
      if (expire) begin
        halted  <= 1'b1;
        elapsed <= '0;
      end else begin
        elapsed <= elapsed + 1'b1;
      end
    end
  end

  // R5: a disarmed timer sits idle in its first period
  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (elapsed == '0 && !in_run && !halted));
  // R2: an accepted restart begins a fresh running period
  a_r2_restart_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !hold && restart) |=> (elapsed == '0 && in_run));
  // R4: the timer stops after an expiry
  a_r4_single_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  // R9: no counting while held in power-on reset
  a_r9_hold_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !expire);

endmodule

// File: rtl/wdog_pg_ctrl.sv
module wdog_pg_ctrl #(
  parameter int unsigned TW  = 16,
  parameter int unsigned DIV = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expire,
  input  logic          drop_en,
  input  logic [TW-1:0] dly,
  output logic          pg
);
  logic          pg_q;
  logic          dtick;
  logic [TW-1:0] dcnt;

  wdog_tick_gen #(.DIV(DIV)) u_dly_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pg_q),
    .tick (dtick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b1;
      dcnt <= '0;
    end else if (pg_q) begin
      if (expire && drop_en) begin
        pg_q <= 1'b0;
        dcnt <= '0;
      end
    end else if (dtick) begin
      if (wdog_pkg::last_step(32'(dcnt), wdog_pkg::eff_delay(32'(dly)))) begin
        pg_q <= 1'b1;
        dcnt <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  assign pg = pg_q;

  // R6: power-good only drops on an enabled expiry
  a_r6_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_q) |-> $past(expire && drop_en));
  // R7: power-good rises only on a delay tick, never on a restart
  a_r7_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_q && !dtick) |=> !pg_q);

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int unsigned CLK_PER_MS   = 200000,
  parameter int unsigned TMO_W        = 16,
  parameter int unsigned LONG_LOW_CYC = 200000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [TMO_W-1:0] wr_data,
  input  logic             wdi,
  output logic             alert_n,
  output logic             pg,
  output logic             por_req,
  output logic             seq_start
);
  import wdog_pkg::*;

  logic [TMO_W-1:0] first_r, run_r, dly_r;
  logic             drop_en_r;
  logic             alert_q;

  logic wr_first, wr_run, wr_cfg, wr_dly, wr_clear;
  logic run_kick, pin_rise, restart, enable;
  logic por_active, presc_clr, ms_tick, expire;

  assign wr_first = wr_en && (wr_addr == ADR_FIRST);
  assign wr_run   = wr_en && (wr_addr == ADR_RUN);
  assign wr_cfg   = wr_en && (wr_addr == ADR_CFG);
  assign wr_dly   = wr_en && (wr_addr == ADR_PGDLY);
  assign wr_clear = wr_en && (wr_addr == ADR_CLEAR);

  assign run_kick = wr_run && (wr_data != '0);
  assign restart  = run_kick || pin_rise;
  assign enable   = (first_r != '0) && (run_r != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_r   <= '0;
      run_r     <= '0;
      dly_r     <= '0;
      drop_en_r <= 1'b0;
    end else begin
      if (wr_first) first_r   <= wr_data;
      if (wr_run)   run_r     <= wr_data;
      if (wr_dly)   dly_r     <= wr_data;
      if (wr_cfg)   drop_en_r <= wr_data[0];
    end
  end

  wdog_pin_mon #(.LONG_LOW_CYC(LONG_LOW_CYC)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (wdi),
    .rise      (pin_rise),
    .por_active(por_active),
    .por_req   (por_req),
    .seq_start (seq_start)
  );

  wdog_tick_gen #(.DIV(CLK_PER_MS)) u_ms_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (presc_clr),
    .tick (ms_tick)
  );

  wdog_timer_core #(.TW(TMO_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ms_tick),
    .enable   (enable),
    .hold     (por_active),
    .restart  (restart),
    .first_lim(first_r),
    .run_lim  (run_r),
    .presc_clr(presc_clr),
    .expire   (expire)
  );

  wdog_pg_ctrl #(.TW(TMO_W), .DIV(CLK_PER_MS)) u_pg (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .drop_en(drop_en_r),
    .dly    (dly_r),
    .pg     (pg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alert_q <= 1'b0;
    else if (expire)   alert_q <= 1'b1;
    else if (wr_clear) alert_q <= 1'b0;
  end

  assign alert_n = !alert_q;

  // R4: the alert only falls on an expiry
  a_r4_alert_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> $past(expire));
  // R4: the alert stays low until a clear write
  a_r4_alert_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && !wr_clear) |=> !alert_n);
  // R5: nothing expires while a timeout register is zero
  a_r5_off_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !expire);

endmodule

// File: tb/wdog_supervisor_bench.sv
module wdog_supervisor_bench;
  localparam int unsigned P   = 4;
  localparam int unsigned LL  = 40;
  localparam int unsigned TW  = 16;
  localparam int EV_ALERT = 0, EV_PGF = 1, EV_PGR = 2, EV_POR = 3, EV_SEQ = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic          wdi = 1'b1;
  logic          alert_n, pg, por_req, seq_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int    q_kind[$];
  int    q_cyc[$];
  string q_req[$];

  bit prev_alert = 1, prev_pg = 1, prev_por = 0, prev_seq = 0;

  wdog_supervisor #(.CLK_PER_MS(P), .TMO_W(TW), .LONG_LOW_CYC(LL)) u_wdog_supervisor (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wdi(wdi), .alert_n(alert_n), .pg(pg), .por_req(por_req), .seq_start(seq_start)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string kind_req(int k);
    case (k)
      EV_ALERT: return "R4";
      EV_PGF, EV_PGR: return "R6";
      EV_POR: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic expect_ev(int kind, int at, string req);
    q_kind.push_back(kind);
    q_cyc.push_back(at);
    q_req.push_back(req);
  endtask

  task automatic take_event(int kind);
    int ek, ec;
    string er;
    checks++;
    if (q_kind.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event kind %0d at cycle %0d, expected none",
               kind_req(kind), kind, cyc);
    end else begin
      ek = q_kind.pop_front();
      ec = q_cyc.pop_front();
      er = q_req.pop_front();
      if (ek != kind || ec != cyc) begin
        errors++;
        $display("FAIL %s actual event %0d at cycle %0d expected event %0d at cycle %0d",
                 er, kind, cyc, ek, ec);
      end
    end
  endtask

  // Monitor: pops the scoreboard as output edges appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_alert && !alert_n) take_event(EV_ALERT);
      if (prev_pg && !pg)         take_event(EV_PGF);
      if (!prev_pg && pg)         take_event(EV_PGR);
      if (!prev_por && por_req)   take_event(EV_POR);
      if (!prev_seq && seq_start) take_event(EV_SEQ);
      if (prev_por) chk("R8 por_req width", int'(por_req), 0);
      if (prev_seq) chk("R9 seq_start width", int'(seq_start), 0);
    end
    prev_alert = alert_n;
    prev_pg    = pg;
    prev_por   = por_req;
    prev_seq   = seq_start;
  end

  task automatic reg_wr(input logic [2:0] a, input int d, output int t0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = TW'(d);
    t0 = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic pin_pulse(output int t0);
    @(negedge clk); wdi = 1'b0;
    repeat (3) @(negedge clk);
    wdi = 1'b1;
    t0 = cyc + 3;
  endtask

  initial begin
    int t0, t1, t2, c0, dummy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 alert_n", int'(alert_n), 1);
    chk("R10 pg", int'(pg), 1);
    chk("R10 por_req", int'(por_req), 0);
    chk("R10 seq_start", int'(seq_start), 0);
    repeat (30) @(negedge clk);

    // R1/R6: first period with power-good drop, delay 2 ticks
    reg_wr(3'd2, 1, dummy);
    reg_wr(3'd3, 2, dummy);
    reg_wr(3'd1, 3, dummy);          // R5: first still zero, no effect
    reg_wr(3'd0, 5, t0);
    expect_ev(EV_ALERT, t0 + 5*P, "R1");
    expect_ev(EV_PGF,   t0 + 5*P, "R6");
    expect_ev(EV_PGR,   t0 + 5*P + 2*P, "R6");
    wait_to(t0 + 35);
    chk("R4 alert held", int'(alert_n), 0);
    reg_wr(3'd4, 0, dummy);
    chk("R4 alert cleared", int'(alert_n), 1);
    repeat (30) @(negedge clk);     // R4: halted, no events

    // R2: restart by running write, second restart pushes expiry out
    reg_wr(3'd1, 3, t0);
    repeat (6) @(negedge clk);
    reg_wr(3'd1, 3, t1);
    expect_ev(EV_ALERT, t1 + 3*P, "R2");
    expect_ev(EV_PGF,   t1 + 3*P, "R2");
    expect_ev(EV_PGR,   t1 + 5*P, "R6");
    wait_to(t1 + 25);
    reg_wr(3'd4, 0, dummy);

    // R3/R7: pin restart, then restart during the power-good delay
    pin_pulse(t0);
    expect_ev(EV_ALERT, t0 + 3*P, "R3");
    expect_ev(EV_PGF,   t0 + 3*P, "R3");
    expect_ev(EV_PGR,   t0 + 5*P, "R7");
    wait_to(t0 + 3*P + 1);
    @(negedge clk); wdi = 1'b0;
    repeat (2) @(negedge clk);
    wdi = 1'b1;
    t2 = cyc + 3;
    expect_ev(EV_PGF, t2 + 3*P, "R7");
    expect_ev(EV_PGR, t2 + 5*P, "R7");
    wait_to(t2 + 5*P + 5);
    chk("R7 pg restored", int'(pg), 1);
    reg_wr(3'd4, 0, dummy);

    // R5: zero writes disarm the timer
    reg_wr(3'd0, 0, dummy);
    repeat (40) @(negedge clk);
    reg_wr(3'd0, 5, t0);
    repeat (10) @(negedge clk);
    reg_wr(3'd1, 0, dummy);
    repeat (40) @(negedge clk);
    chk("R5 no alert while off", int'(alert_n), 1);
    chk("R5 pg while off", int'(pg), 1);

    // R6: drop disabled, alert only; arming via running write uses first period
    reg_wr(3'd2, 0, dummy);
    reg_wr(3'd1, 3, t0);
    expect_ev(EV_ALERT, t0 + 5*P, "R1");
    wait_to(t0 + 5*P + 10);
    chk("R6 pg kept high", int'(pg), 1);
    reg_wr(3'd4, 0, dummy);

    // R6: zero delay acts as one tick
    reg_wr(3'd2, 1, dummy);
    reg_wr(3'd3, 0, dummy);
    pin_pulse(t0);
    expect_ev(EV_ALERT, t0 + 3*P, "R3");
    expect_ev(EV_PGF,   t0 + 3*P, "R6");
    expect_ev(EV_PGR,   t0 + 4*P, "R6");
    wait_to(t0 + 4*P + 6);
    reg_wr(3'd4, 0, dummy);

    // R8: a low level shorter than the threshold gives no request
    reg_wr(3'd0, 0, dummy);
    @(negedge clk); wdi = 1'b0;
    repeat (LL - 5) @(negedge clk);
    wdi = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 short low", int'(por_req), 0);

    // R8/R9: long low, hold, then sequence start and first period
    @(negedge clk); wdi = 1'b0; c0 = cyc;
    expect_ev(EV_POR, c0 + 2 + LL, "R8");
    wait_to(c0 + LL + 5);
    reg_wr(3'd0, 5, dummy);
    repeat (30) @(negedge clk);
    chk("R9 no alert in reset hold", int'(alert_n), 1);
    @(negedge clk); wdi = 1'b1; t0 = cyc + 3;
    expect_ev(EV_SEQ,   t0, "R9");
    expect_ev(EV_ALERT, t0 + 5*P, "R9");
    expect_ev(EV_PGF,   t0 + 5*P, "R9");
    expect_ev(EV_PGR,   t0 + 6*P, "R9");
    wait_to(t0 + 6*P + 8);

    chk("R9 scoreboard drained", q_kind.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual %0d expected %0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule